// File: doc/BRIEF.md
# Sequential Endpoint Buffer Allocator

This block keeps the configuration of sixteen endpoints of a USB device controller: the control OUT endpoint (index 0), the control IN endpoint (index 1), and data endpoints 1 to 14 (indices 2 to 15). A configuration byte sets five things for an endpoint: whether it is enabled, whether it is isochronous or bulk/interrupt, whether it is OUT or IN, whether it has one or two buffers, and the buffer size. Firmware writes one byte per endpoint through a simple write port.

Buffer memory is not laid out as each endpoint is written. The layout is built only when all sixteen endpoints have been written in order, from index 0 to index 15. When the write to index 15 completes such an ordered pass, a fixed-length walk assigns packed base addresses in ascending index order. When the walk ends, the block pulses a done flag. If the endpoints fit in memory, it also marks every enabled endpoint's buffer valid. Any later write that changes how much memory an endpoint takes drops the valid state of every endpoint. A bus reset disables every endpoint.

Top module: `ep_buf_alloc`

## Requirements
- R1: After reset, `alloc_done` and `alloc_overflow` are 0, every `ep_valid` bit is 0 and every base address is 0.
- R2: A write to index 15 that completes an ordered pass starts the layout walk. The walk begins with a write to index 0 followed by accepted writes to 1, 2, … 15. `alloc_done` is high for exactly one cycle, after the 16th rising edge following the edge that accepted the index-15 write.
- R3: Configuration byte layout: bit 7 is enable, bit 6 is isochronous, bit 5 is IN, bit 4 is double buffering, and bits 3:0 are the size code. The size code gives a buffer of (code+1)*8 bytes.
- R4: Base addresses are assigned in ascending index order and packed with no gaps. An enabled endpoint takes its buffer size, or twice that size when double buffered. A disabled endpoint takes no space and reports base 0.
- R5: When a walk ends with a total that fits in the 2048-byte memory, `ep_valid` equals the set of enabled endpoints.
- R6: When the total exceeds the memory capacity, `alloc_overflow` is set and no `ep_valid` bit is set.
- R7: A write whose index is not the expected next index restarts the sequence: the next expected index becomes 1 if index 0 was written and 0 otherwise. An index-15 write outside an ordered pass starts no walk.
- R8: The configuration bytes written to the control endpoints are ignored. They are stored as enabled, single buffered and 64 bytes, with direction OUT for index 0 and IN for index 1.
- R9: After a walk, a write that changes enable, double buffering or size of any endpoint clears every `ep_valid` bit. A write that changes only direction or type leaves them unchanged.
- R10: `bus_reset` disables every endpoint, clears valid bits, overflow and base addresses, aborts any walk, and restarts the sequence at index 0.
- R11: Configuration writes that arrive while a walk is running are ignored. They do not change the stored configuration or the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | USB bus reset seen, one-cycle or longer pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Endpoint index of the write (0 control OUT, 1 control IN, 2..15 data endpoints 1..14) |
| cfg_data | input | 8 | Configuration byte |
| ep_base | output | 176 | Base byte address of each endpoint, 11 bits per endpoint, index i at bits [11*i+10:11*i] |
| ep_valid | output | 16 | Buffer valid flag per endpoint |
| alloc_done | output | 1 | One-cycle pulse when a layout walk ends |
| alloc_overflow | output | 1 | Last walk exceeded memory capacity |

## Verification
The layout is tried with several configurations. A mixed pass includes disabled, double-buffered and isochronous endpoints and junk control bytes; it separates correct packing from skipped or mis-sized slots and shows that control bytes are ignored. An all-maximum pass exposes overflow handling. A pass with one skipped index shows that the walk is held back until a fresh ordered pass. Writes that change only direction and writes that change size tell apart the two kinds of reconfiguration. A write during a walk and a bus reset in mid-life show that the stored state is protected and then discarded.

// File: rtl/epa_pkg.sv
package epa_pkg;

    // Packed field order matches the configuration byte (bit 7 down to bit 0).
    typedef struct packed {
        logic       en;
        logic       iso;
        logic       dir_in;
        logic       dbl;
        logic [3:0] size_code;
    } ep_cfg_t;

    localparam int CFG_W       = 8;
    localparam int NUM_CTRL    = 2;
    localparam logic [3:0] CTRL_SIZE_CODE = 4'd7;

    function automatic ep_cfg_t ctrl_default(input logic is_in);
        ep_cfg_t c;
        c.en        = 1'b1;
        c.iso       = 1'b0;
        c.dir_in    = is_in;
        c.dbl       = 1'b0;
        c.size_code = CTRL_SIZE_CODE;
        return c;
    endfunction

    // True when two configurations claim a different amount of memory.
    function automatic logic mem_differs(input ep_cfg_t a, input ep_cfg_t b);
        return (a.en != b.en) || (a.dbl != b.dbl) || (a.size_code != b.size_code);
    endfunction

endpackage

// File: rtl/epa_cfg_bank.sv
module epa_cfg_bank
    import epa_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int IDX_W  = $clog2(NUM_EP)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_reset,
    input  logic                       wr_acc,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [CFG_W-1:0]           wr_data,
    output logic [NUM_EP*CFG_W-1:0]    cfg_flat,
    output logic                       mem_change
);

    typedef struct packed {
        ep_cfg_t [NUM_EP-1:0] cfg;
    } bank_st_t;

    bank_st_t st_d, st_q;
    ep_cfg_t  new_cfg;

    always_comb begin
        st_d       = st_q;
        mem_change = 1'b0;
        new_cfg    = ep_cfg_t'(wr_data);
        if (wr_idx < IDX_W'(NUM_CTRL)) begin
            new_cfg = ctrl_default(wr_idx == IDX_W'(1));
        end
        if (bus_reset) begin
            for (int i = 0; i < NUM_EP; i++) begin
                st_d.cfg[i].en = 1'b0;
            end
        end else if (wr_acc) begin
            mem_change        = mem_differs(new_cfg, st_q.cfg[wr_idx]);
            st_d.cfg[wr_idx]  = new_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_flat = st_q.cfg;

    // R8: control OUT slot holds its fixed setting whatever byte was written
    a_r8_ctrl_out_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !bus_reset && wr_idx == '0) |=> (cfg_flat[CFG_W-1:0] == CFG_W'(ctrl_default(1'b0))));

    // R10: after a bus reset no endpoint is enabled
    a_r10_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (st_q.cfg[0].en == 1'b0 && st_q.cfg[NUM_EP-1].en == 1'b0));

endmodule

// File: rtl/epa_seq_track.sv
module epa_seq_track #(
    parameter int NUM_EP = 16,
    parameter int IDX_W  = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             wr_acc,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             start
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EP - 1);

    typedef struct packed {
        logic [IDX_W-1:0] nxt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (bus_reset) begin
            st_d.nxt = '0;
        end else if (wr_acc) begin
            if (wr_idx == st_q.nxt) begin
                if (wr_idx == LAST) begin
                    start    = 1'b1;
                    st_d.nxt = '0;
                end else begin
                    st_d.nxt = st_q.nxt + 1'b1;
                end
            end else begin
                st_d.nxt = (wr_idx == '0) ? IDX_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an out-of-order write (not index 0) sends the expectation back to 0
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !bus_reset && wr_idx != st_q.nxt && wr_idx != '0) |=> (st_q.nxt == '0));

    // R10: bus reset restarts the sequence
    a_r10_seq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (st_q.nxt == '0));

endmodule

// File: rtl/epa_layout_walk.sv
module epa_layout_walk
    import epa_pkg::*;
#(
    parameter int NUM_EP     = 16,
    parameter int UNIT_BYTES = 8,
    parameter int MEM_BYTES  = 2048,
    parameter int IDX_W      = $clog2(NUM_EP),
    parameter int ADDR_W     = $clog2(MEM_BYTES),
    parameter int SUM_W      = $clog2(NUM_EP * 32 * UNIT_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_reset,
    input  logic                    start,
    input  logic                    mem_change,
    input  logic [NUM_EP*CFG_W-1:0] cfg_flat,
    output logic                    busy,
    output logic [NUM_EP*ADDR_W-1:0] base_flat,
    output logic [NUM_EP-1:0]       valid,
    output logic                    overflow,
    output logic                    done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EP - 1);

    typedef struct packed {
        logic                              busy;
        logic [IDX_W-1:0]                  idx;
        logic [SUM_W-1:0]                  sum;
        logic [NUM_EP-1:0][ADDR_W-1:0]     base;
        logic [NUM_EP-1:0]                 valid;
        logic                              ovf;
        logic                              done;
    } walk_st_t;

    walk_st_t           st_d, st_q;
    ep_cfg_t            cur;
    logic [SUM_W-1:0]   foot;
    logic [SUM_W-1:0]   nsum;
    logic [NUM_EP-1:0]  en_vec;

    function automatic logic [SUM_W-1:0] footprint(input ep_cfg_t c);
        logic [SUM_W-1:0] one;
        one = SUM_W'((32'(c.size_code) + 32'd1) * 32'(UNIT_BYTES));
        if (!c.en) begin
            return '0;
        end
        return c.dbl ? (one << 1) : one;
    endfunction

    always_comb begin
        for (int i = 0; i < NUM_EP; i++) begin
            en_vec[i] = cfg_flat[i*CFG_W + CFG_W - 1];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cur       = ep_cfg_t'(cfg_flat[st_q.idx*CFG_W +: CFG_W]);
        foot      = footprint(cur);
        nsum      = st_q.sum + foot;
        if (bus_reset) begin
            st_d = '0;
        end else if (start) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.sum   = '0;
            st_d.valid = '0;
            st_d.ovf   = 1'b0;
        end else begin
            if (mem_change) begin
                st_d.valid = '0;
            end
            if (st_q.busy) begin
                st_d.base[st_q.idx] = cur.en ? st_q.sum[ADDR_W-1:0] : '0;
                st_d.sum            = nsum;
                if (st_q.idx == LAST) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    if (nsum > SUM_W'(MEM_BYTES)) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.valid = en_vec;
                    end
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign base_flat = st_q.base;
    assign valid     = st_q.valid;
    assign overflow  = st_q.ovf;
    assign done      = st_q.done;

    // Walk length counter used only by the R2 check below.
    logic [IDX_W:0] run_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
        end else if (start || bus_reset) begin
            run_cnt_q <= '0;
        end else if (st_q.busy) begin
            run_cnt_q <= run_cnt_q + 1'b1;
        end
    end

    // R2: done ends a walk of exactly NUM_EP cycles
    a_r2_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt_q == (IDX_W+1)'(NUM_EP)));

    // R2: done is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: overflow never coexists with a valid buffer
    a_r6_no_valid_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (valid == '0));

    // R9: a memory-changing write drops every valid bit
    a_r9_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mem_change |=> (valid == '0));

    // R11: no walk is restarted while one is running
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    // R10: bus reset clears valid flags and aborts the walk
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (valid == '0 && !busy && !overflow));

    generate
        for (genvar g = 0; g < NUM_EP; g++) begin : g_vchk
            // R5: only enabled endpoints may be valid
            a_r5_valid_enabled: assert property (@(posedge clk) disable iff (!rst_n)
                valid[g] |-> en_vec[g]);
        end
    endgenerate

endmodule

// File: rtl/ep_buf_alloc.sv
module ep_buf_alloc
    import epa_pkg::*;
#(
    parameter int NUM_EP     = 16,
    parameter int UNIT_BYTES = 8,
    parameter int MEM_BYTES  = 2048,
    localparam int IDX_W     = $clog2(NUM_EP),
    localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_reset,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [7:0]               cfg_data,
    output logic [NUM_EP*ADDR_W-1:0] ep_base,
    output logic [NUM_EP-1:0]        ep_valid,
    output logic                     alloc_done,
    output logic                     alloc_overflow
);

    logic                    busy;
    logic                    wr_acc;
    logic                    start;
    logic                    mem_change;
    logic [NUM_EP*CFG_W-1:0] cfg_flat;

    assign wr_acc = cfg_we && !busy && !bus_reset;

    epa_cfg_bank #(
        .NUM_EP (NUM_EP),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .wr_acc     (wr_acc),
        .wr_idx     (cfg_idx),
        .wr_data    (cfg_data),
        .cfg_flat   (cfg_flat),
        .mem_change (mem_change)
    );

    epa_seq_track #(
        .NUM_EP (NUM_EP),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_acc    (wr_acc),
        .wr_idx    (cfg_idx),
        .start     (start)
    );

    epa_layout_walk #(
        .NUM_EP     (NUM_EP),
        .UNIT_BYTES (UNIT_BYTES),
        .MEM_BYTES  (MEM_BYTES),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .start      (start),
        .mem_change (mem_change),
        .cfg_flat   (cfg_flat),
        .busy       (busy),
        .base_flat  (ep_base),
        .valid      (ep_valid),
        .overflow   (alloc_overflow),
        .done       (alloc_done)
    );

endmodule

// File: tb/ep_buf_alloc_test.sv
`timescale 1ns/1ps
module ep_buf_alloc_test;

    localparam int NEP  = 16;
    localparam int AW   = 11;
    localparam int MEM  = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_reset = 1'b0;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_idx = '0;
    logic [7:0]        cfg_data = '0;
    logic [NEP*AW-1:0] ep_base;
    logic [NEP-1:0]    ep_valid;
    logic              alloc_done;
    logic              alloc_overflow;

    int errors = 0;
    int checks = 0;
    logic [7:0] pass_cfg [NEP];

    always #2.5 clk = ~clk;

    ep_buf_alloc uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_reset      (bus_reset),
        .cfg_we         (cfg_we),
        .cfg_idx        (cfg_idx),
        .cfg_data       (cfg_data),
        .ep_base        (ep_base),
        .ep_valid       (ep_valid),
        .alloc_done     (alloc_done),
        .alloc_overflow (alloc_overflow)
    );

    // ---------------- behavioural reference model ----------------
    int m_cfg [NEP];
    int m_next, m_cnt;
    bit m_busy, m_ovf, m_done;
    bit m_valid [NEP];
    int m_base [NEP];

    function automatic int fp_bytes(input int c);
        int b;
        if ((c & 8'h80) == 0) return 0;
        b = ((c & 15) + 1) * 8;
        if ((c & 8'h10) != 0) b = b * 2;
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cfg[i]) begin
                m_cfg[i] = 0; m_valid[i] = 0; m_base[i] = 0;
            end
            m_next = 0; m_cnt = 0; m_busy = 0; m_ovf = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (bus_reset) begin
                foreach (m_cfg[i]) begin
                    m_cfg[i] = m_cfg[i] & 8'h7F; m_valid[i] = 0; m_base[i] = 0;
                end
                m_next = 0; m_busy = 0; m_ovf = 0;
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    int run;
                    run = 0;
                    m_busy = 0; m_done = 1;
                    for (int i = 0; i < NEP; i++) begin
                        m_base[i] = (fp_bytes(m_cfg[i]) != 0) ? (run % MEM) : 0;
                        run += fp_bytes(m_cfg[i]);
                    end
                    m_ovf = (run > MEM);
                    for (int i = 0; i < NEP; i++)
                        m_valid[i] = !m_ovf && ((m_cfg[i] & 8'h80) != 0);
                end
            end else if (cfg_we) begin
                int idx, nc;
                idx = int'(cfg_idx);
                nc = int'(cfg_data);
                if (idx == 0) nc = 8'h87;
                if (idx == 1) nc = 8'hA7;
                if ((nc & 8'h9F) != (m_cfg[idx] & 8'h9F))
                    foreach (m_valid[i]) m_valid[i] = 0;
                m_cfg[idx] = nc;
                if (idx == m_next) begin
                    if (idx == NEP-1) begin
                        m_next = 0; m_busy = 1; m_cnt = NEP; m_ovf = 0;
                        foreach (m_valid[i]) m_valid[i] = 0;
                    end else begin
                        m_next++;
                    end
                end else begin
                    m_next = (idx == 0) ? 1 : 0;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int base_of(input int i);
        return int'(ep_base[i*AW +: AW]);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            int vexp;
            vexp = 0;
            foreach (m_valid[i]) if (m_valid[i]) vexp |= (1 << i);
            chk(alloc_done == m_done, "R2 done vs model", int'(alloc_done), int'(m_done));
            chk(alloc_overflow == m_ovf, "R6 overflow vs model", int'(alloc_overflow), int'(m_ovf));
            chk(int'(ep_valid) == vexp, "R5 valid vs model", int'(ep_valid), vexp);
            if (!m_busy && !m_ovf) begin
                for (int i = 0; i < NEP; i++)
                    if (base_of(i) != m_base[i])
                        chk(1'b0, "R4 base vs model", base_of(i), m_base[i]);
            end
        end
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic wr(input int idx, input int data);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic full_pass();
        for (int i = 0; i < NEP; i++) wr(i, int'(pass_cfg[i]));
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20; k++) begin
            if (alloc_done) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(alloc_done == 0 && alloc_overflow == 0, "R1 flags after reset", int'({alloc_done, alloc_overflow}), 0);
        chk(ep_valid == '0, "R1 valid after reset", int'(ep_valid), 0);
        chk(ep_base == '0, "R1 bases after reset", base_of(15), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Mixed pass: junk control bytes, disabled, double, iso endpoints (R3)
        pass_cfg[0] = 8'h00; pass_cfg[1] = 8'h5A;
        pass_cfg[2] = 8'h83; pass_cfg[3] = 8'h00; pass_cfg[4] = 8'h91; pass_cfg[5] = 8'hCF;
        for (int i = 6; i < NEP; i++) pass_cfg[i] = 8'h81;
        full_pass();
        // R2: done after the 16th edge following the final write
        repeat (15) @(negedge clk);
        chk(alloc_done == 0, "R2 done not early", int'(alloc_done), 0);
        @(negedge clk);
        chk(alloc_done == 1, "R2 done on 16th edge", int'(alloc_done), 1);
        chk(base_of(1) == 64, "R8 control IN base", base_of(1), 64);
        chk(base_of(2) == 128, "R4 packed base idx2", base_of(2), 128);
        chk(base_of(3) == 0, "R4 disabled base", base_of(3), 0);
        chk(base_of(4) == 160, "R3 double slot base", base_of(4), 160);
        chk(base_of(6) == 320, "R3 double+iso sizes", base_of(6), 320);
        chk(ep_valid == 16'hFFF7, "R5 valid equals enabled", int'(ep_valid), 16'hFFF7);
        @(negedge clk);
        chk(alloc_done == 0, "R2 done one cycle", int'(alloc_done), 0);

        // R9: direction-only change keeps valid, size change clears all
        wr(5, 8'hEF);
        @(negedge clk);
        chk(ep_valid == 16'hFFF7, "R9 dir change keeps valid", int'(ep_valid), 16'hFFF7);
        wr(5, 8'hCE);
        @(negedge clk);
        chk(ep_valid == '0, "R9 size change clears all", int'(ep_valid), 0);

        // R7: skip index 8, then index 15 must not start a walk
        for (int i = 0; i < NEP; i++) if (i != 8) wr(i, int'(pass_cfg[i]));
        begin
            bit seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                if (alloc_done) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R7 no walk after skipped index", int'(seen), 0);
        end

        // R11: write during a walk is ignored
        full_pass();
        @(negedge clk);
        wr(2, 8'h8F);
        wait_done();
        chk(alloc_done == 1, "R11 walk finished", int'(alloc_done), 1);
        chk(base_of(4) == 160, "R11 ignored write kept layout", base_of(4), 160);
        @(negedge clk);
        chk(ep_valid == 16'hFFF7, "R11 no invalidation from ignored write", int'(ep_valid), 16'hFFF7);

        // R6: oversubscribed pass
        for (int i = 2; i < NEP; i++) pass_cfg[i] = 8'h9F;
        full_pass();
        wait_done();
        chk(alloc_overflow == 1, "R6 overflow set", int'(alloc_overflow), 1);
        chk(ep_valid == '0, "R6 no valid on overflow", int'(ep_valid), 0);

        // R10: successful pass, then bus reset
        for (int i = 2; i < NEP; i++) pass_cfg[i] = 8'h81;
        full_pass();
        wait_done();
        @(negedge clk);
        chk(ep_valid == 16'hFFFF, "R5 all enabled valid", int'(ep_valid), 16'hFFFF);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        chk(ep_valid == '0 && alloc_overflow == 0, "R10 bus reset clears", int'(ep_valid), 0);
        chk(base_of(2) == 0, "R10 bases cleared", base_of(2), 0);
        for (int i = 1; i < NEP; i++) wr(i, int'(pass_cfg[i]));
        begin
            bit seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                if (alloc_done) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R10 sequence restarted at 0", int'(seen), 0);
        end
        full_pass();
        wait_done();
        chk(alloc_done == 1, "R10 fresh pass after reset", int'(alloc_done), 1);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule